// File: doc/BRIEF.md
# ECC Event Capture Registers

This block sits beside a flash-read ECC decoder and records diagnostics on its error events. The decoder raises a one-cycle pulse on one of two event lines: one for a single-bit error it has corrected, one for an error it cannot correct. Each pulse arrives together with the details of the failing bus access: address, attributes, master identifier and read data. If software has enabled reporting for that class of event, the block latches all of those details together. It also sets a sticky status flag for the class.

Software reaches the block through a simple word-indexed register port with a combinational read path. It uses a control register to enable each class, a status register whose flags clear when written with 1, and read-only capture registers. The capture registers always hold the most recent enabled event. An interrupt request stays high while any flag is set and its class is still enabled.

Top module: `ecc_capture_regs`

## Requirements
- R1: After reset the control word (index 0) and the status word (index 1) read 0, and `irq` is low.
- R2: The control word at index 0 is writable and reads back in bits [1:0]. Bit 0 enables correctable-event reporting and bit 1 enables non-correctable-event reporting. All other bits read 0.
- R3: An enabled event captures the bus address with its low PAGE_OFS bits cleared (five bits by default). The captured page address reads at index 2 from the cycle after the event.
- R4: The same enabled event captures the following, readable from the cycle after the event:
  - the attributes in index 3 bits [7:0];
  - the master identifier in index 3 bits [11:8];
  - the low data word at index 4;
  - the high data word at index 5.
- R5: An enabled correctable event sets status bit 0. An enabled non-correctable event sets status bit 1.
- R6: An event whose class is disabled changes no capture register and sets no flag.
- R7: Each new enabled event overwrites every field of the earlier capture.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If a clear and a new enabled event for the same flag arrive in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when some status flag is set and its enable bit is set. Turning an enable off drops `irq` but keeps the flag.
- R11: Index 3 bit 31 records the class of the captured event: 1 for non-correctable, 0 for correctable. When both enabled classes arrive together, both flags are set and the captured class is non-correctable.
- R12: Indices 6 and 7 read 0. Writes to indices 2 to 5 do not change the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_cor | input | 1 | Corrected single-bit error event pulse |
| evt_unc | input | 1 | Non-correctable error event pulse |
| acc_addr | input | 32 | Bus address of the faulting access |
| acc_attr | input | 8 | Access attributes |
| acc_master | input | 4 | Master identifier |
| acc_data | input | 64 | Read data of the access |
| reg_idx | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check several rules:
- an enabled event loads the page-aligned address and sets its class flag, even when a clear arrives in the same cycle;
- a non-correctable capture records its class bit;
- the capture holds still when no enabled event arrives;
- a flag can only rise after an enabled event of its class.

Only the bench scenarios show the register map as software sees it. That covers field positions, overwrite by a later event, and the write-0 and write-1 behaviour of the status word. It also covers writes to read-only words being ignored, the interrupt dropping when an enable is turned off, and the priority given to the non-correctable details when both classes arrive in the same cycle.

// File: rtl/ecc_capture_regs.sv
module ecc_capture_regs #(
  parameter int ADDR_W   = 32,
  parameter int ATTR_W   = 8,
  parameter int MID_W    = 4,
  parameter int PAGE_OFS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_cor,
  input  logic              evt_unc,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ATTR_W-1:0] acc_attr,
  input  logic [MID_W-1:0]  acc_master,
  input  logic [63:0]       acc_data,
  input  logic [2:0]        reg_idx,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam int INFO_PAD = 31 - ATTR_W - MID_W;
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-PAGE_OFS){1'b1}}, {PAGE_OFS{1'b0}}};

  logic [1:0]        en_q;
  logic [1:0]        flag_q;
  logic [ADDR_W-1:0] cap_addr;
  logic [ATTR_W-1:0] cap_attr;
  logic [MID_W-1:0]  cap_mid;
  logic [63:0]       cap_data;
  logic              cap_unc;

  wire take_cor = evt_cor & en_q[0];
  wire take_unc = evt_unc & en_q[1];
  wire take     = take_cor | take_unc;
  wire wr_ctrl  = reg_wr && reg_idx == 3'd0;
  wire wr_stat  = reg_wr && reg_idx == 3'd1;
  wire [1:0] clr = wr_stat ? reg_wdata[1:0] : 2'b00;
  wire unused_wdata = ^reg_wdata[31:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 2'b00;
      flag_q <= 2'b00;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata[1:0];
      flag_q <= (flag_q & ~clr) | {take_unc, take_cor};
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      cap_addr <= acc_addr & PAGE_MASK;
      cap_attr <= acc_attr;
      cap_mid  <= acc_master;
      cap_data <= acc_data;
      cap_unc  <= take_unc;
    end
  end

  always_comb begin
    case (reg_idx)
      3'd0:    reg_rdata = {30'd0, en_q};
      3'd1:    reg_rdata = {30'd0, flag_q};
      3'd2:    reg_rdata = 32'(cap_addr);
      3'd3:    reg_rdata = {cap_unc, {INFO_PAD{1'b0}}, cap_mid, cap_attr};
      3'd4:    reg_rdata = cap_data[31:0];
      3'd5:    reg_rdata = cap_data[63:32];
      default: reg_rdata = 32'd0;
    endcase
  end

  assign irq = |(flag_q & en_q);

  p_addr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cor && en_q[0]) || (evt_unc && en_q[1]) |=> cap_addr == ($past(acc_addr) & PAGE_MASK));

  p_cor_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cor && en_q[0] |=> flag_q[0]);

  p_unc_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_unc && en_q[1] |=> flag_q[1]);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !((evt_cor && en_q[0]) || (evt_unc && en_q[1])) |=> $stable(cap_addr) && $stable(cap_data));

  p_cor_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(evt_cor && en_q[0]));

  p_class_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_unc && en_q[1] |=> cap_unc);

endmodule

// File: tb/ecc_capture_regs_bench.sv
module ecc_capture_regs_bench;
  logic clk = 0, rst_n = 0;
  logic evt_cor = 0, evt_unc = 0;
  logic [31:0] acc_addr = 0;
  logic [7:0] acc_attr = 0;
  logic [3:0] acc_master = 0;
  logic [63:0] acc_data = 0;
  logic [2:0] reg_idx = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_capture_regs u_ecc_capture_regs (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    reg_idx = idx; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk); reg_idx = idx; reg_wdata = v; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse(input logic c, input logic u, input logic [31:0] a,
                       input logic [7:0] at, input logic [3:0] m, input logic [63:0] d);
    @(negedge clk);
    evt_cor = c; evt_unc = u; acc_addr = a; acc_attr = at; acc_master = m; acc_data = d;
    @(negedge clk);
    evt_cor = 0; evt_unc = 0; acc_addr = 32'hdead_beef; acc_data = '1;
  endtask

  task automatic check_capture(input string req, input logic [31:0] a, input logic [7:0] at,
                               input logic [3:0] m, input logic [63:0] d, input logic cls);
    logic [31:0] v;
    rd(3'd2, v); check({req, " addr"}, v, a & 32'hffff_ffe0);
    rd(3'd3, v); check({req, " info"}, v, {cls, 19'd0, m, at});
    rd(3'd4, v); check({req, " dlo"}, v, d[31:0]);
    rd(3'd5, v); check({req, " dhi"}, v, d[63:32]);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 stat", v, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(3'd0, 32'hffff_fffe); rd(3'd0, v); check("R2 ctrl", v, 2);
    wr(3'd0, 32'h3); rd(3'd0, v); check("R2 ctrl both", v, 3);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    pulse(1, 0, 32'h1234_567f, 8'ha5, 4'h9, 64'h0123_4567_89ab_cdef);
    check_capture("R3 R4 cor", 32'h1234_567f, 8'ha5, 4'h9, 64'h0123_4567_89ab_cdef, 0);
    rd(3'd1, v); check("R5 cor flag", v, 1);
    check("R10 irq", irq, 1);
    pulse(0, 1, 32'h8000_0041, 8'h3c, 4'h2, 64'hfeed_face_cafe_f00d);
    check_capture("R7 R11 unc", 32'h8000_0041, 8'h3c, 4'h2, 64'hfeed_face_cafe_f00d, 1);
    rd(3'd1, v); check("R5 unc flag", v, 3);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(3'd1, 0); rd(3'd1, v); check("R8 write0", v, 3);
    wr(3'd1, 1); rd(3'd1, v); check("R8 clear bit0", v, 2);
    wr(3'd1, 2); rd(3'd1, v); check("R8 clear bit1", v, 0);
    check("R10 irq low", irq, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(3'd0, 32'h1);
    pulse(0, 1, 32'h5555_5555, 8'h11, 4'h1, 64'h1);
    rd(3'd1, v); check("R6 no unc flag", v, 0);
    check_capture("R6 kept", 32'h8000_0041, 8'h3c, 4'h2, 64'hfeed_face_cafe_f00d, 1);
    wr(3'd0, 32'h0);
    pulse(1, 0, 32'h6666_6666, 8'h22, 4'h2, 64'h2);
    rd(3'd1, v); check("R6 no cor flag", v, 0);
    check_capture("R6 kept2", 32'h8000_0041, 8'h3c, 4'h2, 64'hfeed_face_cafe_f00d, 1);
  endtask

  task automatic t_clear_race;
    logic [31:0] v;
    wr(3'd0, 32'h3);
    pulse(1, 0, 32'h100, 8'h1, 4'h1, 64'h10);
    @(negedge clk);
    reg_idx = 3'd1; reg_wdata = 32'h1; reg_wr = 1;
    evt_cor = 1; acc_addr = 32'h2000_0020; acc_attr = 8'h77; acc_master = 4'h7; acc_data = 64'h77;
    @(negedge clk);
    reg_wr = 0; evt_cor = 0;
    rd(3'd1, v); check("R9 flag kept", v, 1);
    check_capture("R9 capture", 32'h2000_0020, 8'h77, 4'h7, 64'h77, 0);
    wr(3'd0, 32'h2);
    check("R10 irq drops", irq, 0);
    rd(3'd1, v); check("R10 flag stays", v, 1);
    wr(3'd1, 32'h3);
  endtask

  task automatic t_both;
    logic [31:0] v;
    wr(3'd0, 32'h3);
    pulse(1, 1, 32'habcd_ef12, 8'h5a, 4'hc, 64'h0f0f_0f0f_f0f0_f0f0);
    rd(3'd1, v); check("R11 both flags", v, 3);
    check_capture("R11 unc wins", 32'habcd_ef12, 8'h5a, 4'hc, 64'h0f0f_0f0f_f0f0_f0f0, 1);
  endtask

  task automatic t_ro;
    logic [31:0] v;
    for (int i = 2; i < 6; i++) wr(3'(i), 32'h1357_9bdf);
    check_capture("R12 ro", 32'habcd_ef12, 8'h5a, 4'hc, 64'h0f0f_0f0f_f0f0_f0f0, 1);
    rd(3'd6, v); check("R12 idx6", v, 0);
    rd(3'd7, v); check("R12 idx7", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ctrl;
    t_capture;
    t_w1c;
    t_disabled;
    t_clear_race;
    t_both;
    t_ro;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule